// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the host-facing register file of a four-channel, 12-bit digital-to-analog converter, rebuilt as synchronous logic. Every host pin is sampled on the system clock through a two-flop synchronizer. Each channel keeps two registers. The input (first-rank) register collects host data. The output (second-rank) register holds the code the converter would drive. The host never pulses a dedicated load strobe. Instead, the relative order of the chip-select and latch-select edges decides whether a write stops in the input register or also moves on to the output register.

A host can write a full 12-bit word or any mix of 4-bit nibbles. It can stage data in one channel and release it later. It can read back the output register of a channel, and it can clear the whole register file. Readback data appears on a separate output bus together with an enable flag and a valid flag. When no readback is active, the bus is forced to zero.

Top module: `qdac_regif`

## Requirements
- R1: The 2-bit channel address `chan` selects channel A (00), B (01), C (10) or D (11). Each channel keeps its own pair of registers, and a write to one channel leaves the others unchanged.
- R2: A falling edge of `cs_n` while `ls_n` is already low loads the bus data into the input register of the addressed channel. The output register does not change until a transfer.
- R3: A rising edge of `ls_n` while `cs_n` is low copies the addressed channel's input register into its output register.
- R4: If `cs_n` rises before `ls_n` rises, the new data stays in the input register and the output register keeps its old value. A later sequence of `cs_n` low, then `ls_n` falling and rising, releases the staged data.
- R5: Active-low `qsel_n[0]`, `qsel_n[1]` and `qsel_n[2]` enable input bits 3:0, 7:4 and 11:8 respectively. Nibbles whose select is high keep their previous value. When all three selects are high, the whole 12-bit word is loaded.
- R6: While `mode_n` or `tr_n` is low, no load into an input register and no transfer to an output register takes place.
- R7: While `rd_n` and `cs_n` are both low and `clr_n` is high, `dout` carries the addressed channel's output register and `dout_oe` and `rd_valid` are 1. At all other times `dout` is 0 and `dout_oe` and `rd_valid` are 0.
- R8: While `rd_n` is low, chip-select and latch-select edges change neither register of any channel.
- R9: While `clr_n` and `cs_n` are both low, both registers of all four channels are cleared and `dout_oe` is 0. This holds even if `rd_n` is low at the same time.
- R10: A change on any host input takes effect on the third rising clock edge after it. That is the edge on which the registers and the outputs update.
- R11: After `arst_n` is released, `dout`, `dout_oe` and `rd_valid` are 0, and every channel reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Chip select, active low |
| ls_n | input | 1 | Latch select, active low |
| rd_n | input | 1 | Readback request, active low |
| clr_n | input | 1 | Register clear request, active low |
| mode_n | input | 1 | Mode-select control; must be high for writes |
| tr_n | input | 1 | Transparent-load control; must be high for writes |
| qsel_n | input | 3 | Active-low nibble selects |
| chan | input | 2 | Channel address |
| din | input | 12 | Write data |
| dout | output | 12 | Readback data, zero when not enabled |
| dout_oe | output | 1 | Readback bus enable |
| rd_valid | output | 1 | Readback data valid |

## Verification
Every result is due on the third rising edge after the input that causes it. Two edges pass through the synchronizer, and the output register or storage register takes the third. Edge events compare the synchronized level with its copy one cycle older, so they also land on that third edge. The bench changes inputs just after a falling edge and holds each level for five cycles, so all results have settled before sampling at a later falling edge. A directed test checks the exact edge by sampling after the second edge and again after the third.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CH_N  = 4;
  localparam int DW    = 12;
  localparam int NIB_W = 4;
  localparam int NQ    = DW / NIB_W;
  localparam int AW    = $clog2(CH_N);

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] chan_t;
  typedef logic [NQ-1:0] qsel_t;

  typedef struct packed {
    logic cs_n;
    logic ls_n;
    logic rd_n;
    logic clr_n;
    logic mode_n;
    logic tr_n;
  } ctl_t;

  localparam int CTL_W  = $bits(ctl_t);
  localparam int DATA_W = AW + NQ + DW;

  // Bit mask of the word positions a write touches.
  function automatic word_t quad_mask(qsel_t qsel_n);
    word_t m;
    m = '0;
    if (&qsel_n) begin
      m = '1;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (!qsel_n[q]) m[q*NIB_W +: NIB_W] = '1;
      end
    end
    return m;
  endfunction

  function automatic word_t quad_merge(word_t old_w, word_t new_w, qsel_t qsel_n);
    word_t m;
    m = quad_mask(qsel_n);
    return (new_w & m) | (old_w & ~m);
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage[i] <= RST_VAL;
          else         stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stage[i] <= RST_VAL;
          else         stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/qdac_evt.sv
module qdac_evt
  import qdac_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  ctl_t s_ctl,
  output logic ev_clr,
  output logic ev_cap,
  output logic ev_xfer,
  output logic rb_act
);
  logic p_cs_n;
  logic p_ls_n;
  logic wr_ok;
  logic cs_fall;
  logic ls_rise;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      p_cs_n <= 1'b1;
      p_ls_n <= 1'b1;
    end else begin
      p_cs_n <= s_ctl.cs_n;
      p_ls_n <= s_ctl.ls_n;
    end
  end

  always_comb begin
    cs_fall = p_cs_n & ~s_ctl.cs_n;
    ls_rise = ~p_ls_n & s_ctl.ls_n;
    wr_ok   = s_ctl.clr_n & s_ctl.rd_n & s_ctl.mode_n & s_ctl.tr_n;
    ev_clr  = ~s_ctl.clr_n & ~s_ctl.cs_n;
    ev_cap  = wr_ok & cs_fall & ~s_ctl.ls_n;
    ev_xfer = wr_ok & ls_rise & ~s_ctl.cs_n;
    rb_act  = s_ctl.clr_n & ~s_ctl.rd_n & ~s_ctl.cs_n;
  end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  ev_clr,
  input  logic  ev_cap,
  input  logic  ev_xfer,
  input  chan_t chan,
  input  qsel_t qsel_n,
  input  word_t din,
  output word_t out_rank [CH_N]
);
  generate
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
      word_t in_q;
      word_t out_q;
      logic  hit;

      assign hit = (chan == chan_t'(c));

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          in_q  <= '0;
          out_q <= '0;
        end else if (ev_clr) begin
          in_q  <= '0;
          out_q <= '0;
        end else begin
          if (ev_cap && hit)  in_q  <= quad_merge(in_q, din, qsel_n);
          if (ev_xfer && hit) out_q <= in_q;
        end
      end

      assign out_rank[c] = out_q;
    end
  endgenerate
endmodule

// File: rtl/qdac_rdout.sv
module qdac_rdout
  import qdac_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  rb_act,
  input  chan_t chan,
  input  word_t out_rank [CH_N],
  output word_t dout,
  output logic  dout_oe,
  output logic  rd_valid
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dout     <= '0;
      dout_oe  <= 1'b0;
      rd_valid <= 1'b0;
    end else if (rb_act) begin
      dout     <= out_rank[chan];
      dout_oe  <= 1'b1;
      rd_valid <= 1'b1;
    end else begin
      dout     <= '0;
      dout_oe  <= 1'b0;
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qdac_regif.sv
module qdac_regif
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          cs_n,
  input  logic          ls_n,
  input  logic          rd_n,
  input  logic          clr_n,
  input  logic          mode_n,
  input  logic          tr_n,
  input  logic [NQ-1:0] qsel_n,
  input  logic [AW-1:0] chan,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          rd_valid
);
  ctl_t              a_ctl;
  ctl_t              s_ctl;
  logic [CTL_W-1:0]  s_ctl_raw;
  logic [DATA_W-1:0] s_data;
  chan_t             s_chan;
  qsel_t             s_qsel_n;
  word_t             s_din;
  logic              ev_clr;
  logic              ev_cap;
  logic              ev_xfer;
  logic              rb_act;
  word_t             out_rank [CH_N];

  always_comb begin
    a_ctl.cs_n   = cs_n;
    a_ctl.ls_n   = ls_n;
    a_ctl.rd_n   = rd_n;
    a_ctl.clr_n  = clr_n;
    a_ctl.mode_n = mode_n;
    a_ctl.tr_n   = tr_n;
  end

  qdac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .arst_n(arst_n), .d(a_ctl), .q(s_ctl_raw)
  );
  assign s_ctl = ctl_t'(s_ctl_raw);

  qdac_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL({DATA_W{1'b0}})) u_sync_data (
    .clk(clk), .arst_n(arst_n), .d({chan, qsel_n, din}), .q(s_data)
  );
  assign {s_chan, s_qsel_n, s_din} = s_data;

  qdac_evt u_evt (
    .clk(clk), .arst_n(arst_n), .s_ctl(s_ctl),
    .ev_clr(ev_clr), .ev_cap(ev_cap), .ev_xfer(ev_xfer), .rb_act(rb_act)
  );

  qdac_bank u_bank (
    .clk(clk), .arst_n(arst_n),
    .ev_clr(ev_clr), .ev_cap(ev_cap), .ev_xfer(ev_xfer),
    .chan(s_chan), .qsel_n(s_qsel_n), .din(s_din),
    .out_rank(out_rank)
  );

  qdac_rdout u_rdout (
    .clk(clk), .arst_n(arst_n), .rb_act(rb_act), .chan(s_chan),
    .out_rank(out_rank),
    .dout(dout), .dout_oe(dout_oe), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/qdac_regif_chk.sv
module qdac_regif_chk
  import qdac_pkg::*;
(
  input logic  clk,
  input logic  arst_n,
  input logic  ev_clr,
  input logic  ev_cap,
  input logic  ev_xfer,
  input logic  rb_act,
  input word_t dout,
  input logic  dout_oe,
  input logic  rd_valid
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!arst_n)
    rb_act |=> rd_valid);

  a_r7_valid_drops: assert property (@(posedge clk) disable iff (!arst_n)
    !rb_act |=> !rd_valid);

  a_r7_oe_matches_valid: assert property (@(posedge clk) disable iff (!arst_n)
    dout_oe == rd_valid);

  a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!arst_n)
    !dout_oe |-> dout == '0);

  a_r9_clear_disables: assert property (@(posedge clk) disable iff (!arst_n)
    ev_clr |=> !dout_oe);

  a_r8_no_write_in_readback: assert property (@(posedge clk) disable iff (!arst_n)
    rb_act |-> !(ev_cap || ev_xfer));

  a_r2_capture_xfer_apart: assert property (@(posedge clk) disable iff (!arst_n)
    !(ev_cap && ev_xfer));

  a_r10_valid_rise_cause: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rd_valid) |-> $past(rb_act));
endmodule

bind qdac_regif qdac_regif_chk u_chk (
  .clk(clk), .arst_n(arst_n),
  .ev_clr(ev_clr), .ev_cap(ev_cap), .ev_xfer(ev_xfer), .rb_act(rb_act),
  .dout(dout), .dout_oe(dout_oe), .rd_valid(rd_valid)
);

// File: tb/qdac_regif_test.sv
module qdac_regif_test;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        cs_n = 1'b1, ls_n = 1'b1, rd_n = 1'b1, clr_n = 1'b1;
  logic        mode_n = 1'b1, tr_n = 1'b1;
  logic [2:0]  qsel_n = 3'b111;
  logic [1:0]  chan = 2'b00;
  logic [11:0] din = '0;
  logic [11:0] dout;
  logic        dout_oe, rd_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdac_regif uut (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .ls_n(ls_n), .rd_n(rd_n),
    .clr_n(clr_n), .mode_n(mode_n), .tr_n(tr_n), .qsel_n(qsel_n),
    .chan(chan), .din(din), .dout(dout), .dout_oe(dout_oe), .rd_valid(rd_valid)
  );

  // {op[1:0], chan[1:0], qsel_n[2:0], data[11:0], expected readback[11:0]}
  // op 0: load and update, 1: preload only, 2: transfer only
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 2'd0, 3'b111, 12'hABC, 12'hABC},
    {2'd0, 2'd1, 3'b111, 12'h123, 12'h123},
    {2'd1, 2'd2, 3'b111, 12'h5A5, 12'h000},
    {2'd2, 2'd2, 3'b111, 12'h000, 12'h5A5},
    {2'd0, 2'd3, 3'b110, 12'hFFF, 12'h00F},
    {2'd0, 2'd3, 3'b101, 12'h0E0, 12'h0EF},
    {2'd0, 2'd3, 3'b011, 12'h7DD, 12'h7EF},
    {2'd0, 2'd0, 3'b100, 12'h456, 12'hA56},
    {2'd1, 2'd1, 3'b111, 12'hFFF, 12'h123},
    {2'd0, 2'd1, 3'b010, 12'h9F8, 12'h9F8}
  };

  task automatic hold();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_update(logic [1:0] c, logic [2:0] q, logic [11:0] d);
    chan = c; qsel_n = q; din = d;
    ls_n = 1'b0; hold();
    cs_n = 1'b0; hold();
    ls_n = 1'b1; hold();
    cs_n = 1'b1; hold();
  endtask

  task automatic preload(logic [1:0] c, logic [2:0] q, logic [11:0] d);
    chan = c; qsel_n = q; din = d;
    ls_n = 1'b0; hold();
    cs_n = 1'b0; hold();
    cs_n = 1'b1; hold();
    ls_n = 1'b1; hold();
  endtask

  task automatic xfer_only(logic [1:0] c);
    chan = c;
    cs_n = 1'b0; hold();
    ls_n = 1'b0; hold();
    ls_n = 1'b1; hold();
    cs_n = 1'b1; hold();
  endtask

  task automatic readback(logic [1:0] c, output logic [11:0] v, output logic ok);
    chan = c; rd_n = 1'b0; cs_n = 1'b0; hold();
    v = dout; ok = rd_valid & dout_oe;
    rd_n = 1'b1; cs_n = 1'b1; hold();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    logic ok;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    hold();
    // R11 reset state
    chk("R11 dout", dout, 0);
    chk("R11 oe", dout_oe, 0);
    chk("R11 valid", rd_valid, 0);
    for (int c = 0; c < 4; c++) begin
      readback(c[1:0], v, ok);
      chk("R11 channel zero", v, 0);
    end

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][30:29])
        2'd0: load_update(VEC[i][28:27], VEC[i][26:24], VEC[i][23:12]);
        2'd1: preload(VEC[i][28:27], VEC[i][26:24], VEC[i][23:12]);
        default: xfer_only(VEC[i][28:27]);
      endcase
      readback(VEC[i][28:27], v, ok);
      chk("R1/R2/R3/R4/R5 readback", v, VEC[i][11:0]);
      chk("R7 valid during readback", ok, 1);
    end
    // R1 other channels untouched by the sequence
    readback(2'd2, v, ok); chk("R1 channel C kept", v, 12'h5A5);
    readback(2'd3, v, ok); chk("R1 channel D kept", v, 12'h7EF);

    // R10 exact latency of readback
    chan = 2'd0; rd_n = 1'b0; cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 not yet valid after two edges", {dout_oe, rd_valid}, 0);
    @(negedge clk);
    chk("R10 valid on third edge", {dout_oe, rd_valid}, 2'b11);
    chk("R10 data on third edge", dout, 12'hA56);
    rd_n = 1'b1; cs_n = 1'b1; hold();
    chk("R7 bus idle after readback", {dout, dout_oe, rd_valid}, 0);

    // R6 mode / transparent controls block writes
    mode_n = 1'b0; load_update(2'd1, 3'b111, 12'h333); mode_n = 1'b1; hold();
    readback(2'd1, v, ok); chk("R6 mode_n low blocks", v, 12'h9F8);
    tr_n = 1'b0; load_update(2'd1, 3'b111, 12'h444); tr_n = 1'b1; hold();
    xfer_only(2'd1);
    readback(2'd1, v, ok); chk("R6 tr_n low blocks load", v, 12'h9F8);

    // R8 writes ignored during readback
    chan = 2'd0; qsel_n = 3'b111; din = 12'h777;
    rd_n = 1'b0; ls_n = 1'b0; hold();
    cs_n = 1'b0; hold();
    ls_n = 1'b1; hold();
    chk("R8 readback during write attempt", dout, 12'hA56);
    rd_n = 1'b1; cs_n = 1'b1; hold();
    xfer_only(2'd0);
    readback(2'd0, v, ok); chk("R8 registers untouched", v, 12'hA56);

    // R9 clear, with priority over readback
    preload(2'd2, 3'b111, 12'hBEE);
    chan = 2'd0; clr_n = 1'b0; rd_n = 1'b0; cs_n = 1'b0; hold();
    chk("R9 clear overrides readback", {dout, dout_oe, rd_valid}, 0);
    clr_n = 1'b1; hold();
    chk("R9 channel A cleared", dout, 0);
    chk("R7 valid after clear released", rd_valid, 1);
    rd_n = 1'b1; cs_n = 1'b1; hold();
    for (int c = 1; c < 4; c++) begin
      readback(c[1:0], v, ok);
      chk("R9 output rank cleared", v, 0);
    end
    xfer_only(2'd2);
    readback(2'd2, v, ok); chk("R9 input rank cleared", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule